// File: doc/BRIEF.md
# Reset-Sampled Debug Mode Controller

This block sits beside a processor core and owns the core's soft reset. After the hard reset input goes away it holds the soft reset for a fixed number of cycles and then releases it. Three cycles before that release it samples the debug strobe input. The sampled value becomes the debug-enable state for the whole time until the next hard reset. Debug capability is therefore a choice made once per reset and cannot be turned on by software later.

One cycle after release, the block starts the core. It pulses a fetch-start strobe, unless the debug strobe was high at every edge up to release and is still high one edge later. In that case it pulses debug entry instead, so a board with no boot code can be debugged from the first instruction.

After start-up, debug event requests pass through a per-event enable mask. A masked-in event sends the core into debug mode when debug is enabled. When debug is disabled it only raises a freeze output. A resume input leaves debug mode and clears freeze. The block also produces the permission that guards the development-support registers.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: `softRstN` is low while `hardRstN` is low. It stays low through the first RELEASE_CYCLES-1 rising edges after `hardRstN` goes high, goes high at edge RELEASE_CYCLES, and then stays high until the next hard reset.
- R2: `debugEnabled` is 0 during hard reset. At edge RELEASE_CYCLES-3 after release (three edges before `softRstN` rises) it takes the value of `dbgStrobe`, and it keeps that value until the next hard reset.
- R3: The value of `dbgStrobe` at any edge other than the sample edge has no effect on `debugEnabled`.
- R4: At edge RELEASE_CYCLES+1, `debugEntry` pulses for one cycle and `inDebug` sets if `dbgStrobe` was high at every edge 1..RELEASE_CYCLES+1 and debug is enabled. Otherwise `fetchStart` pulses for one cycle. The two are never high together.
- R5: After start-up, with debug enabled and `inDebug` low, an edge where some bit of `evtReq` is high and the same bit of the event-enable register is 1 raises `debugEntry` for one cycle and sets `inDebug`. Events seen while `inDebug` is high give no further pulse.
- R6: With debug disabled, a masked-in event sets `freeze`. `debugEntry` and `inDebug` never go high.
- R7: After start-up, `resumeReq` at an edge clears `inDebug` and `freeze`. This takes priority over an event at the same edge.
- R8: `regAccessOk` is high exactly when `inDebug` is high or `userMode` is low (supervisor state).
- R9: The event-enable register is all zeros after hard reset. An `evtEnWr` pulse loads `evtEnData` only when `regAccessOk` is high at that edge, and is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous hard reset, active low |
| dbgStrobe | input | 1 | Debug clock/strobe pin, sampled for enable and boot entry |
| evtReq | input | NUM_EVENTS | Debug event requests |
| evtEnWr | input | 1 | Write strobe for the event-enable register |
| evtEnData | input | NUM_EVENTS | Data for the event-enable register |
| userMode | input | 1 | Core privilege state, 1 = user, 0 = supervisor |
| resumeReq | input | 1 | Leave debug mode and clear freeze |
| softRstN | output | 1 | Soft reset to the core, active low |
| debugEnabled | output | 1 | Latched debug-enable state |
| fetchStart | output | 1 | One-cycle pulse that starts the reset-vector fetch |
| debugEntry | output | 1 | One-cycle pulse that sends the core into debug mode |
| inDebug | output | 1 | Core is in debug mode |
| freeze | output | 1 | Freeze indication used when debug is disabled |
| regAccessOk | output | 1 | Development-support register access permitted |

## Verification
The bench places strobe patterns around the reset release. It drops the strobe only at the sample edge, only at an early edge, and only at the edge after release. A design that samples one cycle off latches the wrong enable. A design that ignores the strobe's history, or its value after release, takes a false boot entry instead of fetching. User-mode writes to the enable mask are followed by events that would hit the mask, so a write that should have been blocked shows up as a spurious freeze or entry. A resume given at the same edge as an event checks that resume wins. A design that re-enters debug mode shows a second entry pulse.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

  // Strobes from the reset sequencer to the datapath
  typedef struct packed {
    logic sampleNow;   // edge three cycles before soft reset release
    logic preRelease;  // soft reset still asserted
    logic startNow;    // first edge after release
    logic running;     // start-up finished, events are live
  } seqStrobes_t;

endpackage

// File: rtl/dbg_rst_seq.sv
module dbg_rst_seq
  import dbg_mode_pkg::*;
#(
  parameter int RELEASE_CYCLES = 6
) (
  input  logic        clk,
  input  logic        hardRstN,
  output logic        softRstN,
  output seqStrobes_t seq
);

  localparam int CW = $clog2(RELEASE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_INIT  = CW'(RELEASE_CYCLES);
  localparam logic [CW-1:0] SAMPLE_AT = CW'(4);
  localparam logic [CW-1:0] LAST_AT   = CW'(1);

  logic [CW-1:0] relCnt;
  logic          softRel;
  logic          started;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      relCnt  <= CNT_INIT;
      softRel <= 1'b0;
      started <= 1'b0;
    end else begin
      if (relCnt != '0) relCnt <= relCnt - CW'(1);
      if (relCnt == LAST_AT) softRel <= 1'b1;
      if (softRel && !started) started <= 1'b1;
    end
  end

  always_comb begin
    seq.sampleNow  = (relCnt == SAMPLE_AT) && !softRel;
    seq.preRelease = !softRel;
    seq.startNow   = softRel && !started;
    seq.running    = started;
  end

  assign softRstN = softRel;

  assert_release_sticky_R1: assert property (@(posedge clk) disable iff (!hardRstN)
    softRel |=> softRel);

  assert_sample_precedes_release_R2: assert property (@(posedge clk) disable iff (!hardRstN)
    seq.sampleNow |=> !softRel);

  assert_start_after_release_R4: assert property (@(posedge clk) disable iff (!hardRstN)
    seq.startNow |=> started);

endmodule

// File: rtl/dbg_mode_dp.sv
module dbg_mode_dp
  import dbg_mode_pkg::*;
#(
  parameter int NUM_EVENTS = 4
) (
  input  logic                  clk,
  input  logic                  hardRstN,
  input  seqStrobes_t           seq,
  input  logic                  dbgStrobe,
  input  logic [NUM_EVENTS-1:0] evtReq,
  input  logic                  evtEnWr,
  input  logic [NUM_EVENTS-1:0] evtEnData,
  input  logic                  userMode,
  input  logic                  resumeReq,
  output logic                  debugEnabled,
  output logic                  fetchStart,
  output logic                  debugEntry,
  output logic                  inDebug,
  output logic                  freeze,
  output logic                  regAccessOk
);

  logic                  dbgEn;
  logic                  strobeHeld;
  logic [NUM_EVENTS-1:0] evtEn;
  logic [NUM_EVENTS-1:0] evtHit;
  logic                  anyHit;
  logic                  bootEntry;

  for (genvar i = 0; i < NUM_EVENTS; i++) begin : g_mask
    assign evtHit[i] = evtReq[i] & evtEn[i];
  end

  assign anyHit      = |evtHit;
  assign bootEntry   = strobeHeld && dbgStrobe && dbgEn;
  assign regAccessOk = inDebug || !userMode;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      dbgEn      <= 1'b0;
      strobeHeld <= 1'b1;
      evtEn      <= '0;
      inDebug    <= 1'b0;
      freeze     <= 1'b0;
      fetchStart <= 1'b0;
      debugEntry <= 1'b0;
    end else begin
      fetchStart <= 1'b0;
      debugEntry <= 1'b0;
      if (seq.sampleNow)  dbgEn <= dbgStrobe;
      if (seq.preRelease) strobeHeld <= strobeHeld & dbgStrobe;
      if (seq.startNow) begin
        if (bootEntry) begin
          debugEntry <= 1'b1;
          inDebug    <= 1'b1;
        end else begin
          fetchStart <= 1'b1;
        end
      end else if (seq.running) begin
        if (resumeReq) begin
          inDebug <= 1'b0;
          freeze  <= 1'b0;
        end else if (anyHit) begin
          if (dbgEn) begin
            if (!inDebug) begin
              debugEntry <= 1'b1;
              inDebug    <= 1'b1;
            end
          end else begin
            freeze <= 1'b1;
          end
        end
      end
      if (evtEnWr && regAccessOk) evtEn <= evtEnData;
    end
  end

  assign debugEnabled = dbgEn;

  assert_enable_frozen_R3: assert property (@(posedge clk) disable iff (!hardRstN)
    !seq.sampleNow |=> $stable(debugEnabled));

  assert_start_exclusive_R4: assert property (@(posedge clk) disable iff (!hardRstN)
    !(fetchStart && debugEntry));

  assert_entry_single_R5: assert property (@(posedge clk) disable iff (!hardRstN)
    debugEntry |=> !debugEntry);

  assert_no_debug_when_off_R6: assert property (@(posedge clk) disable iff (!hardRstN)
    !debugEnabled |-> (!inDebug && !debugEntry));

  assert_resume_clears_R7: assert property (@(posedge clk) disable iff (!hardRstN)
    (seq.running && resumeReq) |=> (!inDebug && !freeze));

  assert_blocked_write_R9: assert property (@(posedge clk) disable iff (!hardRstN)
    (evtEnWr && !regAccessOk) |=> $stable(evtEn));

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int RELEASE_CYCLES = 6,
  parameter int NUM_EVENTS     = 4
) (
  input  logic                  clk,
  input  logic                  hardRstN,
  input  logic                  dbgStrobe,
  input  logic [NUM_EVENTS-1:0] evtReq,
  input  logic                  evtEnWr,
  input  logic [NUM_EVENTS-1:0] evtEnData,
  input  logic                  userMode,
  input  logic                  resumeReq,
  output logic                  softRstN,
  output logic                  debugEnabled,
  output logic                  fetchStart,
  output logic                  debugEntry,
  output logic                  inDebug,
  output logic                  freeze,
  output logic                  regAccessOk
);

  seqStrobes_t seq;

  dbg_rst_seq #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_seq (
    .clk      (clk),
    .hardRstN (hardRstN),
    .softRstN (softRstN),
    .seq      (seq)
  );

  dbg_mode_dp #(.NUM_EVENTS(NUM_EVENTS)) u_dp (
    .clk          (clk),
    .hardRstN     (hardRstN),
    .seq          (seq),
    .dbgStrobe    (dbgStrobe),
    .evtReq       (evtReq),
    .evtEnWr      (evtEnWr),
    .evtEnData    (evtEnData),
    .userMode     (userMode),
    .resumeReq    (resumeReq),
    .debugEnabled (debugEnabled),
    .fetchStart   (fetchStart),
    .debugEntry   (debugEntry),
    .inDebug      (inDebug),
    .freeze       (freeze),
    .regAccessOk  (regAccessOk)
  );

  assert_access_rule_R8: assert property (@(posedge clk) disable iff (!hardRstN)
    (inDebug || !userMode) |-> regAccessOk);

endmodule

// File: tb/dbg_mode_ctrl_test.sv
module dbg_mode_ctrl_test;

  localparam int RC = 6;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          hardRstN = 1'b0;
  logic          dbgStrobe = 1'b0;
  logic [NE-1:0] evtReq = '0;
  logic          evtEnWr = 1'b0;
  logic [NE-1:0] evtEnData = '0;
  logic          userMode = 1'b0;
  logic          resumeReq = 1'b0;
  logic softRstN, debugEnabled, fetchStart, debugEntry, inDebug, freeze, regAccessOk;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_mode_ctrl #(.RELEASE_CYCLES(RC), .NUM_EVENTS(NE)) uut (
    .clk(clk), .hardRstN(hardRstN), .dbgStrobe(dbgStrobe), .evtReq(evtReq),
    .evtEnWr(evtEnWr), .evtEnData(evtEnData), .userMode(userMode),
    .resumeReq(resumeReq), .softRstN(softRstN), .debugEnabled(debugEnabled),
    .fetchStart(fetchStart), .debugEntry(debugEntry), .inDebug(inDebug),
    .freeze(freeze), .regAccessOk(regAccessOk)
  );

  // Behavioural reference model
  int            k = 0;
  bit            mEn = 0, mHeld = 1, mSoft = 0, mFetch = 0, mEntry = 0, mDbg = 0, mFrz = 0;
  logic [NE-1:0] mMask = '0;

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!hardRstN) begin
      k = 0; mEn = 0; mHeld = 1; mSoft = 0; mFetch = 0; mEntry = 0;
      mDbg = 0; mFrz = 0; mMask = '0;
    end else begin
      bit acc;
      acc = mDbg || !userMode;
      k++;
      mFetch = 0; mEntry = 0;
      if (k == RC - 3) mEn = dbgStrobe;
      if (k <= RC) mHeld = mHeld && dbgStrobe;
      mSoft = (k >= RC);
      if (k == RC + 1) begin
        if (mHeld && dbgStrobe && mEn) begin mEntry = 1; mDbg = 1; end
        else mFetch = 1;
      end else if (k > RC + 1) begin
        if (resumeReq) begin mDbg = 0; mFrz = 0; end
        else if ((evtReq & mMask) != '0) begin
          if (mEn) begin
            if (!mDbg) begin mEntry = 1; mDbg = 1; end
          end else mFrz = 1;
        end
      end
      if (evtEnWr && acc) mMask = evtEnData;
    end
    #1;
    if (!done) begin
      chk("R1 softRstN", softRstN, mSoft);
      chk("R2/R3 debugEnabled", debugEnabled, mEn);
      chk("R4 fetchStart", fetchStart, mFetch);
      chk("R4/R5 debugEntry", debugEntry, mEntry);
      chk("R5/R7 inDebug", inDebug, mDbg);
      chk("R6/R7 freeze", freeze, mFrz);
      chk("R8 regAccessOk", regAccessOk, mDbg || !userMode);
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // pat bit i is the strobe level at edge i+1 after release
  task automatic doReset(logic [15:0] pat);
    @(negedge clk);
    hardRstN = 1'b0; dbgStrobe = pat[0];
    evtReq = '0; evtEnWr = 0; resumeReq = 0; userMode = 0;
    tick(2);
    hardRstN = 1'b1;
    for (int i = 0; i <= RC; i++) begin
      dbgStrobe = pat[i];
      tick();
    end
    dbgStrobe = 1'b0;
    tick();
  endtask

  task automatic drive(logic [NE-1:0] req, logic wr, logic [NE-1:0] data, logic usr, logic res);
    evtReq = req; evtEnWr = wr; evtEnData = data; userMode = usr; resumeReq = res;
    tick();
    evtReq = '0; evtEnWr = 0; resumeReq = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    // A: strobe held high throughout, boot entry (R4)
    doReset(16'hFFFF);
    drive('0, 0, '0, 1, 0);            // R8 in debug while user
    drive(4'b0001, 0, '0, 0, 0);       // R9 zero mask: ignored
    drive('0, 0, '0, 0, 1);            // R7 resume
    drive('0, 1, 4'b0011, 1, 0);       // R9 user write blocked
    drive(4'b0011, 0, '0, 1, 0);       // R9 must give no entry
    drive('0, 1, 4'b0011, 0, 0);       // R9 supervisor write
    drive(4'b0010, 0, '0, 0, 0);       // R5 entry
    drive(4'b0001, 0, '0, 1, 0);       // R5 no second pulse
    drive('0, 1, 4'b0100, 1, 0);       // R8/R9 write allowed in debug
    drive(4'b0100, 0, '0, 0, 1);       // R7 resume beats event
    drive(4'b0100, 0, '0, 1, 0);       // R5 new entry
    tick(2);
    // B: strobe only at sample edge, enabled but fetch (R2, R4)
    doReset(16'h1 << (RC - 4));
    drive('0, 1, 4'b1000, 0, 0);
    drive(4'b1000, 0, '0, 0, 0);       // R5
    tick(2);
    // C: strobe low at first edge, enabled, no boot entry (R3, R4)
    doReset(16'hFFFE);
    drive(4'b1111, 0, '0, 0, 0);       // R9 mask reset zero
    // D: strobe low only at sample edge, disabled (R2, R6)
    doReset(16'hFFFF & ~(16'h1 << (RC - 4)));
    drive('0, 1, 4'b0101, 0, 0);
    drive(4'b0100, 0, '0, 1, 0);       // R6 freeze
    drive(4'b0001, 0, '0, 1, 0);
    drive('0, 1, 4'b1111, 1, 0);       // R8 user: blocked
    drive('0, 0, '0, 0, 1);            // R7 clears freeze
    drive(4'b1010, 0, '0, 0, 0);       // R9 blocked write: no freeze
    drive(4'b0001, 0, '0, 0, 1);       // R7 priority
    tick(2);
    // E: strobe low only after release, enabled, fetch (R4)
    doReset(16'hFFFF & ~(16'h1 << RC));
    tick(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule